// File: doc/BRIEF.md
# Frame Buffer Read-Ahead Fetcher

This block runs on the memory-side clock and keeps a display pixel store topped up. At each frame start it walks a rectangular frame in memory. Each line begins at the frame base plus a multiple of the line pitch. The block cuts every line into read bursts and presents them on a valid/ready request interface. The store itself lives outside the block. The fetcher only keeps count: returned beats raise its fill level, and the consumer reports the bytes it drains through a pop count.

A burst is requested only when the whole of it fits into the store. The space check counts both the bytes already held and the bytes requested but not yet returned. The number of bursts awaiting their last beat is capped by a programmable limit. When the display side reports that it ran dry, the block issues nothing more for the rest of that frame and resumes at the next frame start. Underruns and error-flagged beats latch interrupt status bits, which a mask turns into a single interrupt line. A bus options value of 0x408 decodes to 8-beat bursts and 4 outstanding requests.

Top module: `fb_prefetch`

## Requirements
- R1: At frame start the fetcher walks lines 0 to count-1. Line k starts at base + k*pitch, and each burst inside a line starts where the previous one ended (previous address + beats*8).
- R2: A burst has min(B, ceil(remaining line bytes / 8)) beats. B is the 5-bit burst field with 0 read as 1 and values above 16 read as 16.
- R3: A request is presented only while held bytes + in-flight bytes + beats*8 is at most 2048, so the two counts never sum above 2048.
- R4: The in-flight count rises by beats*8 on each accepted request and falls by 8 on each returned beat. The fill level rises by 8 per returned beat and falls by pop_bytes.
- R5: Accepted requests whose last beat has not returned never exceed the outstanding limit. The limit is the 4-bit field, with 0 read as 16.
- R6: After an underrun pulse, no request is presented until the next frame start, which restarts the walk at the base address. No request is presented in a cycle carrying frame_start or underrun_in.
- R7: irq_raw bit 3 latches on an underrun and bit 1 latches on a returned beat flagged as an error. A one in irq_clear clears the matching bit, and a new set in the same cycle wins. irq is high when any raw bit is also set in irq_mask.
- R8: busy is high from a frame start until the last burst of the frame is accepted or an underrun occurs. A frame with zero lines or zero line bytes issues nothing.
- R9: After reset no request is presented, and busy, fill_level, inflight_bytes, irq_raw and irq are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | 32 | Frame base address |
| cfg_line_bytes | input | 16 | Bytes fetched per line |
| cfg_line_count | input | 12 | Lines per frame |
| cfg_pitch | input | 32 | Address step between lines |
| cfg_burst | input | 5 | Burst length field in beats |
| cfg_outst | input | 4 | Outstanding request limit field |
| frame_start | input | 1 | Pulse that begins a new frame |
| underrun_in | input | 1 | Pulse from the display side: store ran dry |
| rd_req_valid | output | 1 | Read request presented |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Byte address of the burst |
| rd_req_beats | output | 5 | Beats in the burst (8 bytes each) |
| rd_beat_valid | input | 1 | One 8-byte beat returned into the store |
| rd_beat_last | input | 1 | Returned beat ends its burst |
| rd_beat_err | input | 1 | Returned beat carries an error response |
| pop_bytes | input | 12 | Bytes drained from the store this cycle |
| irq_mask | input | 4 | Interrupt enable per raw bit |
| irq_clear | input | 4 | Write-one-to-clear pulses for raw bits |
| busy | output | 1 | Frame walk in progress and not halted |
| fill_level | output | 12 | Bytes held in the store |
| inflight_bytes | output | 12 | Bytes requested but not yet returned |
| irq_raw | output | 4 | Latched interrupt status |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest states to reach are a store that is exactly full with requests still pending and a full set of outstanding bursts. The bench creates the first by running a 4 KB frame with the drain switched off: the walk must stall at exactly 16 bursts of 128 bytes and a fill level of 2048, and it must continue once draining resumes. It creates the second by holding back all returned beats while small bursts are accepted, then comparing the number of handshakes against the decoded limit. An underrun is injected in the middle of a frame with draining active, and the following frame is checked to restart from the base address.

// File: rtl/fb_prefetch_pkg.sv
package fb_prefetch_pkg;

  localparam int IRQ_BUSERR_BIT   = 1;
  localparam int IRQ_UNDERRUN_BIT = 3;

  typedef logic [4:0] burst_fld_t;
  typedef logic [3:0] outst_fld_t;

  // Decoded burst length: 0 behaves as 1, anything above the ceiling clamps.
  function automatic logic [4:0] eff_burst(input logic [4:0] fld, input int max_b);
    if (fld == 5'd0) return 5'd1;
    if (int'(fld) > max_b) return 5'(max_b);
    return fld;
  endfunction

  // Decoded outstanding limit: 0 selects the hardware maximum.
  function automatic logic [4:0] eff_outst(input logic [3:0] fld, input int max_o);
    if (fld == 4'd0) return 5'(max_o);
    return {1'b0, fld};
  endfunction

  // Beats for the next chunk of a line with rem bytes left.
  function automatic logic [4:0] chunk_beats(input int rem, input logic [4:0] burst,
                                             input int beat_bytes);
    int rb;
    rb = (rem + beat_bytes - 1) / beat_bytes;
    if (rb < int'(burst)) return 5'(rb);
    return burst;
  endfunction

endpackage

// File: rtl/fb_addr_gen.sv
module fb_addr_gen #(
  parameter int AW         = 32,
  parameter int LBW        = 16,
  parameter int LCW        = 12,
  parameter int BEAT_BYTES = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           halt,
  input  logic [AW-1:0]  base,
  input  logic [LBW-1:0] line_bytes,
  input  logic [LCW-1:0] line_count,
  input  logic [AW-1:0]  pitch,
  input  logic [4:0]     burst_lim,
  input  logic           take,
  output logic           active,
  output logic [AW-1:0]  req_addr,
  output logic [4:0]     req_beats
);
  import fb_prefetch_pkg::*;

  logic [AW-1:0]  line_addr_q;
  logic [LBW-1:0] offset_q;
  logic [LCW-1:0] line_idx_q;
  logic           active_q;
  logic [LBW-1:0] rem;
  logic           end_of_line;
  logic           last_line;

  always_comb begin
    rem         = line_bytes - offset_q;
    req_beats   = chunk_beats(int'(rem), burst_lim, BEAT_BYTES);
    req_addr    = line_addr_q + AW'(offset_q);
    end_of_line = (int'(req_beats) * BEAT_BYTES) >= int'(rem);
    last_line   = (int'(line_idx_q) + 1) >= int'(line_count);
  end

  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_addr_q <= '0;
      offset_q    <= '0;
      line_idx_q  <= '0;
      active_q    <= 1'b0;
    end else if (start) begin
      line_addr_q <= base;
      offset_q    <= '0;
      line_idx_q  <= '0;
      active_q    <= (line_count != '0) && (line_bytes != '0);
    end else if (halt) begin
      active_q    <= 1'b0;
    end else if (take && active_q) begin
      if (end_of_line) begin
        offset_q    <= '0;
        line_addr_q <= line_addr_q + pitch;
        line_idx_q  <= line_idx_q + 1'b1;
        if (last_line) active_q <= 1'b0;
      end else begin
        offset_q <= offset_q + LBW'(int'(req_beats) * BEAT_BYTES);
      end
    end
  end

endmodule

// File: rtl/fb_credit.sv
module fb_credit #(
  parameter int CAP_BYTES  = 2048,
  parameter int BEAT_BYTES = 8,
  parameter int FW         = 12,
  parameter int OW         = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [4:0]    req_beats,
  input  logic          beat_in,
  input  logic          beat_end,
  input  logic [FW-1:0] pop_bytes,
  input  logic [OW-1:0] outst_lim,
  output logic [FW-1:0] fill,
  output logic [FW-1:0] inflight,
  output logic [OW-1:0] outst,
  output logic          room_ok,
  output logic          outst_ok
);
  logic [FW-1:0] fill_q, infl_q;
  logic [OW-1:0] outst_q;
  int            beat_add;
  int            req_bytes;

  always_comb begin
    beat_add  = beat_in ? BEAT_BYTES : 0;
    req_bytes = int'(req_beats) * BEAT_BYTES;
    room_ok   = (int'(fill_q) + int'(infl_q) + req_bytes) <= CAP_BYTES;
    outst_ok  = outst_q < outst_lim;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      infl_q  <= '0;
      outst_q <= '0;
    end else begin
      fill_q  <= FW'(int'(fill_q) + beat_add - int'(pop_bytes));
      infl_q  <= FW'(int'(infl_q) + (take ? req_bytes : 0) - beat_add);
      outst_q <= OW'(int'(outst_q) + (take ? 1 : 0) - (beat_end ? 1 : 0));
    end
  end

  assign fill     = fill_q;
  assign inflight = infl_q;
  assign outst    = outst_q;

endmodule

// File: rtl/fb_irq.sv
module fb_irq #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clear,
  input  logic [NB-1:0] mask,
  output logic [NB-1:0] raw,
  output logic          irq
);
  logic [NB-1:0] raw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clear) | set;
  end

  assign raw = raw_q;
  assign irq = |(raw_q & mask);

endmodule

// File: rtl/fb_prefetch.sv
module fb_prefetch #(
  parameter int AW         = 32,
  parameter int LBW        = 16,
  parameter int LCW        = 12,
  parameter int CAP_BYTES  = 2048,
  parameter int BEAT_BYTES = 8,
  parameter int MAX_BURST  = 16,
  parameter int MAX_OUTST  = 16,
  parameter int NIRQ       = 4,
  localparam int FW        = $clog2(CAP_BYTES + 1),
  localparam int OW        = $clog2(MAX_OUTST + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LBW-1:0]  cfg_line_bytes,
  input  logic [LCW-1:0]  cfg_line_count,
  input  logic [AW-1:0]   cfg_pitch,
  input  logic [4:0]      cfg_burst,
  input  logic [3:0]      cfg_outst,
  input  logic            frame_start,
  input  logic            underrun_in,
  output logic            rd_req_valid,
  input  logic            rd_req_ready,
  output logic [AW-1:0]   rd_req_addr,
  output logic [4:0]      rd_req_beats,
  input  logic            rd_beat_valid,
  input  logic            rd_beat_last,
  input  logic            rd_beat_err,
  input  logic [FW-1:0]   pop_bytes,
  input  logic [NIRQ-1:0] irq_mask,
  input  logic [NIRQ-1:0] irq_clear,
  output logic            busy,
  output logic [FW-1:0]   fill_level,
  output logic [FW-1:0]   inflight_bytes,
  output logic [NIRQ-1:0] irq_raw,
  output logic            irq
);
  import fb_prefetch_pkg::*;

  // Named internal events, visible to the bound checker.
  logic            evt_take;
  logic            evt_beat;
  logic            evt_beat_end;
  logic            suppress_q;
  logic            walk_active;
  logic            room_ok;
  logic            outst_ok;
  logic [4:0]      burst_lim;
  logic [OW-1:0]   outst_lim;
  logic [OW-1:0]   outst_cnt;
  logic [NIRQ-1:0] irq_set;

  assign burst_lim = eff_burst(cfg_burst, MAX_BURST);
  assign outst_lim = OW'(eff_outst(cfg_outst, MAX_OUTST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           suppress_q <= 1'b0;
    else if (underrun_in) suppress_q <= 1'b1;
    else if (frame_start) suppress_q <= 1'b0;
  end

  assign rd_req_valid = walk_active && !suppress_q && room_ok && outst_ok
                        && !frame_start && !underrun_in;
  assign evt_take     = rd_req_valid && rd_req_ready;
  assign evt_beat     = rd_beat_valid;
  assign evt_beat_end = rd_beat_valid && rd_beat_last;
  assign busy         = walk_active && !suppress_q;

  fb_addr_gen #(
    .AW(AW), .LBW(LBW), .LCW(LCW), .BEAT_BYTES(BEAT_BYTES)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (frame_start),
    .halt       (underrun_in),
    .base       (cfg_base),
    .line_bytes (cfg_line_bytes),
    .line_count (cfg_line_count),
    .pitch      (cfg_pitch),
    .burst_lim  (burst_lim),
    .take       (evt_take),
    .active     (walk_active),
    .req_addr   (rd_req_addr),
    .req_beats  (rd_req_beats)
  );

  fb_credit #(
    .CAP_BYTES(CAP_BYTES), .BEAT_BYTES(BEAT_BYTES), .FW(FW), .OW(OW)
  ) u_credit (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (evt_take),
    .req_beats (rd_req_beats),
    .beat_in   (evt_beat),
    .beat_end  (evt_beat_end),
    .pop_bytes (pop_bytes),
    .outst_lim (outst_lim),
    .fill      (fill_level),
    .inflight  (inflight_bytes),
    .outst     (outst_cnt),
    .room_ok   (room_ok),
    .outst_ok  (outst_ok)
  );

  generate
    for (genvar b = 0; b < NIRQ; b++) begin : g_irq_src
      if (b == IRQ_UNDERRUN_BIT) begin : g_ur
        assign irq_set[b] = underrun_in;
      end else if (b == IRQ_BUSERR_BIT) begin : g_be
        assign irq_set[b] = rd_beat_valid && rd_beat_err;
      end else begin : g_none
        assign irq_set[b] = 1'b0;
      end
    end
  endgenerate

  fb_irq #(.NB(NIRQ)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (irq_set),
    .clear (irq_clear),
    .mask  (irq_mask),
    .raw   (irq_raw),
    .irq   (irq)
  );

endmodule

// File: rtl/fb_prefetch_chk.sv
module fb_prefetch_chk #(
  parameter int CAP_BYTES  = 2048,
  parameter int BEAT_BYTES = 8,
  parameter int FW         = 12,
  parameter int OW         = 5,
  parameter int NIRQ       = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req_valid,
  input logic [4:0]      rd_req_beats,
  input logic [4:0]      burst_lim,
  input logic [FW-1:0]   fill_level,
  input logic [FW-1:0]   inflight_bytes,
  input logic [OW-1:0]   outst_cnt,
  input logic [OW-1:0]   outst_lim,
  input logic            suppress_q,
  input logic            underrun_in,
  input logic            evt_take,
  input logic            evt_beat,
  input logic [NIRQ-1:0] irq_raw
);

  assert_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (int'(fill_level) + int'(inflight_bytes)
                      + int'(rd_req_beats) * BEAT_BYTES) <= CAP_BYTES);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_level) + int'(inflight_bytes)) <= CAP_BYTES);

  assert_outst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    outst_cnt <= outst_lim);

  assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_beats != 5'd0) && (rd_req_beats <= burst_lim));

  assert_quiet_after_underrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_in |=> !rd_req_valid);

  assert_halted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    suppress_q |-> !rd_req_valid);

  assert_underrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_raw[3]) |-> $past(underrun_in));

  assert_inflight_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_take && !evt_beat) |=> $stable(inflight_bytes));

endmodule

bind fb_prefetch fb_prefetch_chk #(
  .CAP_BYTES(CAP_BYTES), .BEAT_BYTES(BEAT_BYTES), .FW(FW), .OW(OW), .NIRQ(NIRQ)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rd_req_valid   (rd_req_valid),
  .rd_req_beats   (rd_req_beats),
  .burst_lim      (burst_lim),
  .fill_level     (fill_level),
  .inflight_bytes (inflight_bytes),
  .outst_cnt      (outst_cnt),
  .outst_lim      (outst_lim),
  .suppress_q     (suppress_q),
  .underrun_in    (underrun_in),
  .evt_take       (evt_take),
  .evt_beat       (evt_beat),
  .irq_raw        (irq_raw)
);

// File: tb/test_fb_prefetch.sv
module test_fb_prefetch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_base, cfg_pitch;
  logic [15:0] cfg_line_bytes;
  logic [11:0] cfg_line_count;
  logic [4:0]  cfg_burst;
  logic [3:0]  cfg_outst;
  logic        frame_start, underrun_in;
  logic        rd_req_valid, rd_req_ready;
  logic [31:0] rd_req_addr;
  logic [4:0]  rd_req_beats;
  logic        rd_beat_valid, rd_beat_last, rd_beat_err;
  logic [11:0] pop_bytes;
  logic [3:0]  irq_mask, irq_clear;
  logic        busy, irq;
  logic [11:0] fill_level, inflight_bytes;
  logic [3:0]  irq_raw;

  fb_prefetch i_fb_prefetch (.*);

  always #10 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int hs_cnt = 0;
  int fill_m = 0;
  int cyc = 0;
  bit pop_on = 0, resp_hold = 0, rdy_mode = 0, err_inject = 0, seq_on = 0;
  bit finished = 0;
  int          pend_q[$];
  logic [31:0] exp_a[$];
  int          exp_b[$];

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic int eb(input int f);
    if (f == 0) return 1;
    if (f > 16) return 16;
    return f;
  endfunction

  function automatic int eo(input int f);
    return (f == 0) ? 16 : f;
  endfunction

  task automatic build_exp(input logic [31:0] base, input int lb, input int cnt,
                           input logic [31:0] pitch, input int bf);
    exp_a.delete(); exp_b.delete();
    for (int ln = 0; ln < cnt; ln++) begin
      int off = 0;
      while (off < lb) begin
        int rb = (lb - off + 7) / 8;
        int b  = (rb < eb(bf)) ? rb : eb(bf);
        exp_a.push_back(base + 32'(ln) * pitch + 32'(off));
        exp_b.push_back(b);
        off += b * 8;
      end
    end
  endtask

  // Request monitor (samples away from the active edge)
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rd_req_valid) begin
        chk((int'(fill_level) + int'(inflight_bytes) + int'(rd_req_beats) * 8) <= 2048,
            "R3 room", int'(fill_level) + int'(inflight_bytes), 2048);
      end
      if (rst_n && rd_req_valid && rd_req_ready) begin
        hs_cnt++;
        pend_q.push_back(int'(rd_req_beats));
        if (seq_on) begin
          if (exp_a.size() == 0) chk(0, "R1 extra request", rd_req_addr, 0);
          else begin
            chk(rd_req_addr == exp_a[0], "R1 address", rd_req_addr, exp_a[0]);
            chk(int'(rd_req_beats) == exp_b[0], "R2 beats", rd_req_beats, exp_b[0]);
            void'(exp_a.pop_front()); void'(exp_b.pop_front());
          end
        end
      end
    end
  end

  // Memory responder and store drain
  initial begin
    rd_beat_valid = 0; rd_beat_last = 0; rd_beat_err = 0;
    pop_bytes = '0; rd_req_ready = 1;
    forever begin
      int p;
      tick();
      p = pop_on ? ((fill_m < 24) ? fill_m : 24) : 0;
      pop_bytes = 12'(p);
      fill_m -= p;
      rd_beat_valid = 0; rd_beat_last = 0; rd_beat_err = 0;
      if (!resp_hold && pend_q.size() > 0) begin
        rd_beat_valid = 1;
        rd_beat_last  = (pend_q[0] == 1);
        rd_beat_err   = err_inject;
        err_inject    = 0;
        pend_q[0] = pend_q[0] - 1;
        if (pend_q[0] == 0) void'(pend_q.pop_front());
        fill_m += 8;
      end
      rd_req_ready = rdy_mode ? ((cyc % 3) != 0) : 1'b1;
      cyc++;
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    summary();
  end

  task automatic pulse_start();
    frame_start = 1; tick(); frame_start = 0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      if (exp_a.size() == 0 && pend_q.size() == 0 && fill_m == 0) break;
      tick();
    end
    repeat (4) tick();
  endtask

  task automatic run_frame(input logic [31:0] base, input int lb, input int cnt,
                           input logic [31:0] pitch, input int bf, input int of);
    cfg_base = base; cfg_line_bytes = 16'(lb); cfg_line_count = 12'(cnt);
    cfg_pitch = pitch; cfg_burst = 5'(bf); cfg_outst = 4'(of);
    build_exp(base, lb, cnt, pitch, bf);
    seq_on = 1; pop_on = 1;
    tick();
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(exp_a.size() == 0, "R1 frame complete", exp_a.size(), 0);
    chk(busy == 0, "R8 busy ends", busy, 0);
    chk(fill_level == 0 && inflight_bytes == 0, "R4 counts settle",
        int'(fill_level) + int'(inflight_bytes), 0);
    tick();
  endtask

  initial begin
    int bursts[9] = '{0, 1, 2, 3, 5, 8, 16, 17, 31};
    int lbs[4]    = '{8, 24, 40, 136};
    int hs0;
    rst_n = 0; frame_start = 0; underrun_in = 0;
    cfg_base = 32'h1000; cfg_pitch = 32'h100; cfg_line_bytes = 16'd64;
    cfg_line_count = 12'd1; cfg_burst = 5'd8; cfg_outst = 4'd4;
    irq_mask = 4'h0; irq_clear = 4'h0;
    repeat (3) tick();
    @(negedge clk);
    chk(rd_req_valid == 0 && busy == 0, "R9 reset idle", {rd_req_valid, busy}, 0);
    chk(fill_level == 0 && inflight_bytes == 0, "R9 reset counts",
        int'(fill_level) + int'(inflight_bytes), 0);
    chk(irq_raw == 0 && irq == 0, "R9 reset irq", irq_raw, 0);
    tick();
    rst_n = 1;
    repeat (5) tick();
    @(negedge clk);
    chk(rd_req_valid == 0, "R9 no request without frame", rd_req_valid, 0);
    tick();

    // Sweep of burst field, line length, line count (R1, R2, R4, R8)
    for (int bi = 0; bi < 9; bi++)
      for (int li = 0; li < 4; li++)
        for (int cn = 1; cn <= 3; cn += 2) begin
          rdy_mode = ((bi + li) % 2) == 1;
          run_frame(32'h0004_0000 + 32'(bi * 4096 + li * 64), lbs[li], cn,
                    32'h200, bursts[bi], (bi % 4) + 1);
        end
    rdy_mode = 0;

    // Zero-line frame (R8)
    hs0 = hs_cnt;
    cfg_line_count = 12'd0; build_exp(0, 0, 0, 0, 1); tick(); pulse_start();
    repeat (30) tick();
    @(negedge clk);
    chk(hs_cnt == hs0 && busy == 0, "R8 empty frame", hs_cnt - hs0, 0);
    tick();

    // Outstanding limit with responses held (R5)
    for (int k = 0; k < 3; k++) begin
      int fo = (k == 0) ? 4 : ((k == 1) ? 0 : 9);
      cfg_base = 32'h8000; cfg_line_bytes = 16'd256; cfg_line_count = 12'd2;
      cfg_pitch = 32'h400; cfg_burst = 5'd1; cfg_outst = 4'(fo);
      build_exp(32'h8000, 256, 2, 32'h400, 1);
      resp_hold = 1; hs0 = hs_cnt;
      tick(); pulse_start();
      repeat (60) tick();
      @(negedge clk);
      chk((hs_cnt - hs0) == eo(fo), "R5 outstanding cap", hs_cnt - hs0, eo(fo));
      tick();
      resp_hold = 0;
      wait_done();
      @(negedge clk);
      chk(exp_a.size() == 0, "R1 after cap release", exp_a.size(), 0);
      tick();
    end

    // Store full, no drain (R3, R4)
    cfg_base = 32'h10000; cfg_line_bytes = 16'd1024; cfg_line_count = 12'd4;
    cfg_pitch = 32'h800; cfg_burst = 5'd16; cfg_outst = 4'd0;
    build_exp(32'h10000, 1024, 4, 32'h800, 16);
    pop_on = 0; hs0 = hs_cnt;
    tick(); pulse_start();
    repeat (400) tick();
    @(negedge clk);
    chk((hs_cnt - hs0) == 16, "R3 stall at capacity", hs_cnt - hs0, 16);
    chk(fill_level == 12'd2048, "R4 fill at capacity", fill_level, 2048);
    chk(inflight_bytes == 0 && rd_req_valid == 0, "R3 no request when full",
        rd_req_valid, 0);
    tick();
    pop_on = 1;
    wait_done();
    @(negedge clk);
    chk(exp_a.size() == 0 && fill_level == 0, "R3 resume after drain", exp_a.size(), 0);
    tick();

    // Underrun mid-frame (R6, R7)
    irq_mask = 4'b1000;
    cfg_base = 32'h20000; cfg_line_bytes = 16'd256; cfg_line_count = 12'd4;
    cfg_pitch = 32'h100; cfg_burst = 5'd2; cfg_outst = 4'd4;
    build_exp(32'h20000, 256, 4, 32'h100, 2);
    rdy_mode = 1;
    tick(); pulse_start();
    for (int i = 0; i < 2000 && (hs_cnt - hs0) < 5; i++) begin hs0 = hs0; tick(); end
    while (exp_a.size() > 59) tick();
    underrun_in = 1; hs0 = hs_cnt; tick(); underrun_in = 0;
    repeat (100) tick();
    @(negedge clk);
    chk(hs_cnt == hs0, "R6 halted after underrun", hs_cnt - hs0, 0);
    chk(busy == 0, "R8 busy drops on underrun", busy, 0);
    chk(irq_raw[3] == 1, "R7 underrun flag", irq_raw[3], 1);
    chk(irq == 1, "R7 masked irq on", irq, 1);
    tick();
    irq_mask = 4'b0000;
    tick(); @(negedge clk);
    chk(irq == 0, "R7 mask blocks irq", irq, 0);
    tick();
    irq_clear = 4'b1000; tick(); irq_clear = 4'b0000;
    @(negedge clk);
    chk(irq_raw == 4'b0000, "R7 clear underrun flag", irq_raw, 0);
    tick();
    wait_done();
    exp_a.delete(); exp_b.delete();
    rdy_mode = 0;
    run_frame(32'h20000, 256, 2, 32'h100, 2, 4);

    // Error beat (R7)
    err_inject = 1; irq_mask = 4'b0010;
    run_frame(32'h30000, 64, 1, 32'h100, 8, 4);
    @(negedge clk);
    chk(irq_raw == 4'b0010, "R7 bus error flag", irq_raw, 2);
    chk(irq == 1, "R7 error irq", irq, 1);
    tick();
    irq_clear = 4'b0010; tick(); irq_clear = 4'b0000;
    @(negedge clk);
    chk(irq_raw == 0 && irq == 0, "R7 clear error flag", irq_raw, 0);

    summary();
  end

endmodule